// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Charge-Pump Control

This block compares two divided pulse trains, one from the reference divider and one from the feedback divider. It turns the difference in their arrival times into pump-up and pump-down commands for an external charge pump. Both pulse inputs are sampled by the system clock, and only their rising edges are used. When the reference edge arrives first, the block raises the up command. When the feedback edge arrives first, it raises the down command. When the second edge arrives, both commands are held high together for a short fixed window and then released. This overlap keeps the detector out of the dead zone when the phase error is small.

A polarity bit swaps the two commands to suit a VCO whose gain is positive or negative. A lock flag is high whenever the pump is not driving one-sided. A power-down bit parks the detector and forces the lock flag high. A boost bit marks 4x pump current and drives an active-low fast-lock switch that brings in a second loop-filter resistor. The comparison rate must stay at or below 10 MHz, and the system clock must be many times faster than that.

The controller has four states. ST_IDLE means the pump is tri-stated. ST_UP means up is active and is waiting for the feedback edge. ST_DN means down is active and is waiting for the reference edge. ST_OVL is the overlap window. The transitions are:
- ST_IDLE to ST_UP on a reference edge, to ST_DN on a feedback edge, and to ST_OVL when both edges arrive together.
- ST_UP to ST_OVL on a feedback edge.
- ST_DN to ST_OVL on a reference edge.
- ST_OVL to ST_IDLE after OVL_CYCLES cycles.
- Any state to ST_IDLE while power-down is set.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: During and after reset: pump_up=0, pump_dn=0, pump_hiz=1, lock_ok=1, fastlock_n=1, pump_boost=0.
- R2: With invert_pol=0, suppose a rising edge of ref_pulse is first sampled at clock edge k while the detector is idle. Then pump_up goes to 1 at edge k+2 and pump_dn stays 0.
- R3: With invert_pol=0, suppose a rising edge of fb_pulse is first sampled at clock edge k while the detector is idle. Then pump_dn goes to 1 at edge k+2 and pump_up stays 0.
- R4: A second edge can arrive on the other input, or both edges can arrive in the same cycle. In either case pump_up and pump_dn are both 1 for exactly OVL_CYCLES (default 3) cycles and then both return to 0. Edges that arrive during this window are discarded.
- R5: pump_up and pump_dn are never 1 together for more than OVL_CYCLES consecutive cycles.
- R6: With invert_pol=1, the two commands are exchanged: a leading reference edge drives pump_dn and a leading feedback edge drives pump_up.
- R7: pump_hiz is 1 exactly when pump_up and pump_dn are both 0.
- R8: lock_ok is 0 while exactly one pump command is active. It is 1 when the pump is tri-stated and also during the overlap window.
- R9: One clock edge after pwr_down=1 is set, both pump commands are 0 and lock_ok is 1. pump_boost is 0 and fastlock_n is 1. Pulse edges that arrive during power-down start no pumping, either then or after release.
- R10: One clock edge after boost=1 is set while powered up, pump_boost is 1 and fastlock_n is 0 (switch closed). With boost=0, fastlock_n is 1.
- R11: Only 0-to-1 transitions count. An input that stays high starts no new comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference-divider output pulse |
| fb_pulse | input | 1 | Feedback-divider output pulse |
| invert_pol | input | 1 | 1 swaps the up and down commands |
| boost | input | 1 | 1 selects 4x pump current |
| pwr_down | input | 1 | 1 parks the detector |
| pump_up | output | 1 | Charge-pump source enable |
| pump_dn | output | 1 | Charge-pump sink enable |
| pump_hiz | output | 1 | Pump output tri-stated |
| lock_ok | output | 1 | Lock detect, high when the pump is not driving one-sided |
| fastlock_n | output | 1 | Fast-lock resistor switch, active low |
| pump_boost | output | 1 | 4x current command to the pump |

## Verification
The assertions check four properties on every cycle:
- the overlap window never runs longer than its length (R5);
- the tri-state flag never coincides with an active command;
- lock is low only during one-sided pumping;
- power-down and boost take effect one edge after they are set.

Only the directed scenarios can show the rest:
- the exact latency from a divider edge to a pump command;
- which command the leading input selects under each polarity;
- that both commands release exactly when the overlap window ends;
- that edges arriving during power-down or on an input held high are discarded.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_OVL  = 2'd3
    } pfd_state_e;
endpackage

// File: rtl/pfd_edge_det.sv
`timescale 1ns/1ps
// Two-flop sampling of each divider pulse, rising-edge strobe per lane.
module pfd_edge_det #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sig_in,
    output logic [LANES-1:0] rise
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic s1_q, s2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= sig_in[g];
                    s2_q <= s1_q;
                end
            end
            assign rise[g] = s1_q & ~s2_q;
        end
    endgenerate
endmodule

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
// Tri-state detector control: one-sided states plus a timed overlap reset.
module pfd_core
    import pfd_pkg::*;
#(
    parameter int OVL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    input  logic halt,
    output logic raw_up,
    output logic raw_dn,
    output logic one_sided
);
    localparam int CW = $clog2(OVL_CYCLES + 1);
    localparam logic [CW-1:0] OVL_LAST = CW'(OVL_CYCLES - 1);

    pfd_state_e state_q, state_d;
    logic [CW-1:0] ovl_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ovl_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OVL && state_d == ST_OVL)
                ovl_cnt_q <= ovl_cnt_q + 1'b1;
            else
                ovl_cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_rise && fb_rise) state_d = ST_OVL;
                    else if (ref_rise)       state_d = ST_UP;
                    else if (fb_rise)        state_d = ST_DN;
                end
                ST_UP:   if (fb_rise)  state_d = ST_OVL;
                ST_DN:   if (ref_rise) state_d = ST_OVL;
                ST_OVL:  if (ovl_cnt_q == OVL_LAST) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        raw_up    = 1'b0;
        raw_dn    = 1'b0;
        one_sided = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_UP:   begin raw_up = 1'b1; one_sided = 1'b1; end
            ST_DN:   begin raw_dn = 1'b1; one_sided = 1'b1; end
            ST_OVL:  begin raw_up = 1'b1; raw_dn = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfd_out_stage.sv
`timescale 1ns/1ps
// Registered pump command stage: polarity, power-down gating, lock, fast-lock.
module pfd_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_up,
    input  logic raw_dn,
    input  logic one_sided,
    input  logic invert,
    input  logic boost,
    input  logic halt,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic lock_ok,
    output logic fastlock_n,
    output logic pump_boost
);
    logic up_d, dn_d;

    always_comb begin
        up_d = invert ? raw_dn : raw_up;
        dn_d = invert ? raw_up : raw_dn;
        if (halt) begin
            up_d = 1'b0;
            dn_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pump_up    <= 1'b0;
            pump_dn    <= 1'b0;
            pump_hiz   <= 1'b1;
            lock_ok    <= 1'b1;
            fastlock_n <= 1'b1;
            pump_boost <= 1'b0;
        end else begin
            pump_up    <= up_d;
            pump_dn    <= dn_d;
            pump_hiz   <= ~(up_d | dn_d);
            lock_ok    <= halt | ~one_sided;
            fastlock_n <= ~(boost & ~halt);
            pump_boost <= boost & ~halt;
        end
    end
endmodule

// File: rtl/pfd_pump_ctrl.sv
`timescale 1ns/1ps
module pfd_pump_ctrl #(
    parameter int OVL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic invert_pol,
    input  logic boost,
    input  logic pwr_down,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic lock_ok,
    output logic fastlock_n,
    output logic pump_boost
);
    logic [1:0] rise;
    logic raw_up, raw_dn, one_sided;

    pfd_edge_det #(.LANES(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({fb_pulse, ref_pulse}),
        .rise   (rise)
    );

    pfd_core #(.OVL_CYCLES(OVL_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (rise[0]),
        .fb_rise   (rise[1]),
        .halt      (pwr_down),
        .raw_up    (raw_up),
        .raw_dn    (raw_dn),
        .one_sided (one_sided)
    );

    pfd_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_up     (raw_up),
        .raw_dn     (raw_dn),
        .one_sided  (one_sided),
        .invert     (invert_pol),
        .boost      (boost),
        .halt       (pwr_down),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .pump_hiz   (pump_hiz),
        .lock_ok    (lock_ok),
        .fastlock_n (fastlock_n),
        .pump_boost (pump_boost)
    );
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
`timescale 1ns/1ps
module pfd_pump_ctrl_chk #(
    parameter int OVL_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic boost,
    input logic pwr_down,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_hiz,
    input logic lock_ok,
    input logic fastlock_n
);
    logic [7:0] both_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 both_cnt <= '0;
        else if (pump_up && pump_dn) begin
            if (both_cnt != 8'hFF) both_cnt <= both_cnt + 8'd1;
        end else                    both_cnt <= '0;
    end

    assert_overlap_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |-> (both_cnt < 8'(OVL_CYCLES)));

    assert_hiz_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pump_hiz |-> (!pump_up && !pump_dn));

    assert_unlock_one_sided_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |-> (pump_up ^ pump_dn));

    assert_pdown_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> (lock_ok && !pump_up && !pump_dn && fastlock_n));

    assert_boost_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(boost && !pwr_down) |-> !fastlock_n);
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk #(.OVL_CYCLES(OVL_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boost      (boost),
    .pwr_down   (pwr_down),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_hiz   (pump_hiz),
    .lock_ok    (lock_ok),
    .fastlock_n (fastlock_n)
);

// File: tb/pfd_pump_ctrl_tb.sv
`timescale 1ns/1ps
module pfd_pump_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0;
    logic invert_pol = 1'b0, boost = 1'b0, pwr_down = 1'b0;
    logic pump_up, pump_dn, pump_hiz, lock_ok, fastlock_n, pump_boost;
    int total = 0;
    int bad = 0;

    // output vector order: {up, dn, hiz, lock, fastlock_n, boost}
    localparam logic [5:0] V_IDLE  = 6'b001110;
    localparam logic [5:0] V_UP    = 6'b100010;
    localparam logic [5:0] V_DN    = 6'b010010;
    localparam logic [5:0] V_BOTH  = 6'b110110;
    localparam logic [5:0] V_BIDLE = 6'b001101;
    localparam logic [5:0] V_BUP   = 6'b100001;

    always #4 clk = ~clk;

    pfd_pump_ctrl #(.OVL_CYCLES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .invert_pol(invert_pol), .boost(boost), .pwr_down(pwr_down),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .lock_ok(lock_ok), .fastlock_n(fastlock_n), .pump_boost(pump_boost)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {pump_up, pump_dn, pump_hiz, lock_ok, fastlock_n, pump_boost};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
        wait_n(4);
    endtask

    task automatic t_reset();
        wait_n(2);
        chk("R1 in reset", V_IDLE);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 after reset", V_IDLE);
    endtask

    task automatic t_ref_lead();
        ref_pulse = 1'b1;
        wait_n(3);
        chk("R2 R8 ref leads", V_UP);
        fb_pulse = 1'b1;
        wait_n(3);
        chk("R4 R8 overlap start", V_BOTH);
        wait_n(2);
        chk("R4 overlap last cycle", V_BOTH);
        wait_n(1);
        chk("R4 R7 release", V_IDLE);
        wait_n(3);
        chk("R11 held inputs", V_IDLE);
        settle();
    endtask

    task automatic t_fb_lead();
        fb_pulse = 1'b1;
        wait_n(3);
        chk("R3 R8 fb leads", V_DN);
        ref_pulse = 1'b1;
        wait_n(3);
        chk("R4 overlap after dn", V_BOTH);
        wait_n(3);
        chk("R4 R7 release after dn", V_IDLE);
        settle();
    endtask

    task automatic t_simul();
        ref_pulse = 1'b1;
        fb_pulse  = 1'b1;
        wait_n(3);
        chk("R4 R8 coincident edges", V_BOTH);
        wait_n(3);
        chk("R4 coincident release", V_IDLE);
        settle();
    endtask

    task automatic t_polarity();
        invert_pol = 1'b1;
        wait_n(2);
        ref_pulse = 1'b1;
        wait_n(3);
        chk("R6 inverted ref leads", V_DN);
        fb_pulse = 1'b1;
        wait_n(6);
        settle();
        fb_pulse = 1'b1;
        wait_n(3);
        chk("R6 inverted fb leads", V_UP);
        ref_pulse = 1'b1;
        wait_n(6);
        settle();
        invert_pol = 1'b0;
        wait_n(2);
    endtask

    task automatic t_pdown();
        pwr_down = 1'b1;
        boost    = 1'b1;
        wait_n(2);
        chk("R9 parked with boost", V_IDLE);
        ref_pulse = 1'b1;
        wait_n(4);
        chk("R9 edge during power-down", V_IDLE);
        pwr_down = 1'b0;
        wait_n(3);
        chk("R9 R10 no stale pumping", V_BIDLE);
        boost = 1'b0;
        settle();
    endtask

    task automatic t_boost();
        boost = 1'b1;
        wait_n(2);
        chk("R10 boost idle", V_BIDLE);
        ref_pulse = 1'b1;
        wait_n(3);
        chk("R10 boost pumping", V_BUP);
        fb_pulse = 1'b1;
        wait_n(6);
        boost = 1'b0;
        wait_n(2);
        chk("R10 boost off", V_IDLE);
        settle();
    endtask

    initial begin
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_simul();
        t_polarity();
        t_pdown();
        t_boost();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1600000;
        total++;
        bad++;
        $display("FAIL watchdog: got hung expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule